// File: doc/BRIEF.md
# Floating-Point Reciprocal Square-Root Estimator

This block returns a coarse approximation of 1/sqrt(x) for a single- or double-precision IEEE-754 operand. A precision select picks the format for each operation. The result carries an 8-bit significand estimate, and software or a later iteration stage can refine it.

The operand is first classified. NaN, zero, negative values and infinities are resolved at once, with the architectural flags and the two mode controls applied. The two controls are flush-to-zero for subnormal inputs and replacement of NaN results with the canonical NaN. A finite positive operand is normalized if it is subnormal. Its exponent parity then picks one of two range reductions, and a computed 256-entry table supplies the significand. The result exponent follows from the input exponent by a fixed offset and a halving.

The block has one register stage. A request presented with `in_valid` produces its result one clock later, qualified by `out_valid`. When an operand is single precision, it sits in the low 32 bits of the operand bus, and the result is returned in the low 32 bits of the result bus.

Top module: `rsq_est`

## Requirements
- R1: A NaN operand gives a NaN result. A quiet NaN is returned unchanged and raises no flag. A signaling NaN, meaning one whose top fraction bit (bit 22 single, bit 51 double) is 0, raises invalid and is returned with that bit set.
- R2: With default-NaN mode on, every NaN result is the canonical NaN: 0x7FC00000 for single precision and 0x7FF8000000000000 for double. A signaling NaN input still raises invalid.
- R3: A zero operand of either sign raises divide-by-zero and returns infinity with the operand's sign (0x7F800000 / 0x7FF0000000000000, with the sign bit set for a negative operand).
- R4: A negative operand that is neither zero nor NaN raises invalid and returns the canonical NaN. This includes negative infinity.
- R5: Positive infinity returns positive zero and raises no flag.
- R6: With flush-to-zero on, a subnormal operand (exponent field 0, fraction nonzero) raises input-denormal and is then handled as a zero of its own sign. It therefore also raises divide-by-zero and returns signed infinity.
- R7: With flush-to-zero off, a subnormal operand is normalized. Its fraction, widened to 52 bits (a single fraction is shifted up by 29), is shifted left n times until bit 51 is set. The working exponent becomes -n. The fraction is then shifted left once more, which drops the leading one.
- R8: The table index is {exponent parity, top 7 widened fraction bits}, so q = 128 + those 7 bits. An odd exponent uses s = floor(256/sqrt((q+0.5)/512) + 0.5). An even exponent uses the same formula with 256 in place of 512. The resulting s always lies in 256..511.
- R9: For a finite positive operand, the result exponent field is (380 - e)/2 for single precision and (3068 - e)/2 for double precision, where e is the working exponent.
- R10: The result fraction is (s - 256) placed in the top 8 fraction bits, with zeros below: bits 22:15 for single precision and bits 51:44 for double. The result sign is 0.
- R11: A finite positive operand raises none of the three flags.
- R12: `out_valid` equals `in_valid` one clock earlier. After reset it is 0, and so are all other outputs.
- R13: For a single-precision operation, result bits 63:32 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present this cycle |
| in_dp | input | 1 | 1 = double precision, 0 = single (low 32 bits) |
| in_ftz | input | 1 | Flush subnormal operands to zero |
| in_dnan | input | 1 | Return canonical NaN for every NaN result |
| in_op | input | 64 | Operand |
| out_valid | output | 1 | Result present this cycle |
| out_res | output | 64 | Estimate or special value |
| out_invalid | output | 1 | Invalid-operation flag |
| out_dzero | output | 1 | Divide-by-zero flag |
| out_idenorm | output | 1 | Input-denormal flag |

## Verification
Input-denormal and divide-by-zero fire together on the same result when a flushed subnormal turns into a signed zero. Invalid and the default-NaN substitution also coincide when a signaling NaN meets default-NaN mode. Both pairings are provoked by directed subnormal and signaling-NaN operands under each control setting, and again by random operands biased towards a zero exponent field. The bench judges them by comparing the whole result word and all three flags against its model in the cycle after issue. A checker property additionally demands that input-denormal never appears without divide-by-zero.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    typedef enum logic [2:0] {
        CLS_NAN,
        CLS_ZERO,
        CLS_NEG,
        CLS_PINF,
        CLS_FIN
    } rsq_cls_e;

    typedef struct packed {
        logic        valid;
        logic [63:0] res;
        logic        inv;
        logic        dz;
        logic        idn;
    } rsq_out_t;

    // Largest s with (2s-1)^2 * (2q+1) <= 2^19 * den, i.e. round(256/sqrt((q+0.5)/den))
    function automatic logic [8:0] rsq_est_value(input int unsigned par,
                                                 input int unsigned top,
                                                 input int unsigned fbits);
        longint q, den, lim, t, s;
        q   = longint'(1 << fbits) + longint'(top);
        den = (par != 0) ? longint'(1 << (fbits + 2)) : longint'(1 << (fbits + 1));
        lim = den * 524288;
        s   = 0;
        for (int b = 8; b >= 0; b--) begin
            t = s | (longint'(1) << b);
            if ((2 * t - 1) * (2 * t - 1) * (2 * q + 1) <= lim)
                s = t;
        end
        return 9'(s);
    endfunction

endpackage

// File: rtl/rsq_unpack.sv
module rsq_unpack
    import rsq_pkg::*;
(
    input  logic        dp,
    input  logic        ftz,
    input  logic [63:0] op,
    output rsq_cls_e    cls,
    output logic        snan,
    output logic        idn,
    output logic        sub,
    output logic [10:0] expo,
    output logic [51:0] frac
);
    logic        sgn;
    logic        exp_max;
    logic        raw_sub;
    logic        flushed;

    always_comb begin
        sgn     = dp ? op[63] : op[31];
        expo    = dp ? op[62:52] : {3'b000, op[30:23]};
        frac    = dp ? op[51:0] : {op[22:0], 29'b0};
        exp_max = dp ? (op[62:52] == 11'h7FF) : (op[30:23] == 8'hFF);
        raw_sub = (expo == 11'd0) && (frac != 52'd0);
        flushed = raw_sub && ftz;
        idn     = flushed;
        sub     = raw_sub && !ftz;
        snan    = exp_max && (frac != 52'd0) && !frac[51];
        if (exp_max && frac != 52'd0)
            cls = CLS_NAN;
        else if (expo == 11'd0 && (frac == 52'd0 || flushed))
            cls = CLS_ZERO;
        else if (sgn)
            cls = CLS_NEG;
        else if (exp_max)
            cls = CLS_PINF;
        else
            cls = CLS_FIN;
    end
endmodule

// File: rtl/rsq_norm.sv
module rsq_norm #(
    parameter int FRAC_IDX = 7
) (
    input  logic                       sub,
    input  logic [10:0]                expo,
    input  logic [51:0]                frac,
    output logic signed [12:0]         e_work,
    output logic [FRAC_IDX-1:0]        idx_frac
);
    localparam int FW = 52;

    logic [5:0] lead_n;

    always_comb begin
        lead_n = 6'd0;
        for (int i = 0; i < FW; i++)
            if (frac[i]) lead_n = 6'(FW - 1 - i);
        if (sub) begin
            e_work   = -13'(signed'({7'b0, lead_n}));
            idx_frac = FRAC_IDX'((frac << (lead_n + 6'd1)) >> (FW - FRAC_IDX));
        end else begin
            e_work   = 13'(signed'({2'b0, expo}));
            idx_frac = FRAC_IDX'(frac >> (FW - FRAC_IDX));
        end
    end
endmodule

// File: rtl/rsq_rom.sv
module rsq_rom
    import rsq_pkg::*;
#(
    parameter int FRAC_IDX = 7
) (
    input  logic [FRAC_IDX:0] idx,
    output logic [8:0]        est
);
    localparam int DEPTH = 2 ** (FRAC_IDX + 1);
    localparam int HALF  = 2 ** FRAC_IDX;

    logic [8:0] tbl [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        assign tbl[g] = rsq_est_value(g / HALF, g % HALF, FRAC_IDX);
    end

    assign est = tbl[idx];
endmodule

// File: rtl/rsq_est.sv
module rsq_est
    import rsq_pkg::*;
#(
    parameter int FRAC_IDX = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_dp,
    input  logic        in_ftz,
    input  logic        in_dnan,
    input  logic [63:0] in_op,
    output logic        out_valid,
    output logic [63:0] out_res,
    output logic        out_invalid,
    output logic        out_dzero,
    output logic        out_idenorm
);
    localparam logic [63:0] DNAN_D  = 64'h7FF8_0000_0000_0000;
    localparam logic [63:0] DNAN_S  = 64'h0000_0000_7FC0_0000;
    localparam logic [63:0] INF_D   = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] INF_S   = 64'h0000_0000_7F80_0000;
    localparam int          KOFF_S  = 380;
    localparam int          KOFF_D  = 3068;

    rsq_cls_e                 cls;
    logic                     snan, idn, sub;
    logic [10:0]              expo;
    logic [51:0]              frac;
    logic signed [12:0]       e_work;
    logic [FRAC_IDX-1:0]      idx_frac;
    logic [8:0]               est;
    logic signed [13:0]       rexp;
    logic [7:0]               est_frac;
    logic [63:0]              dnan_v, quiet_v, fin_v;
    logic                     sgn;

    rsq_out_t out_d, out_q;

    rsq_unpack i_unpack (
        .dp(in_dp), .ftz(in_ftz), .op(in_op), .cls(cls), .snan(snan),
        .idn(idn), .sub(sub), .expo(expo), .frac(frac)
    );

    rsq_norm #(.FRAC_IDX(FRAC_IDX)) i_norm (
        .sub(sub), .expo(expo), .frac(frac), .e_work(e_work), .idx_frac(idx_frac)
    );

    rsq_rom #(.FRAC_IDX(FRAC_IDX)) i_rom (
        .idx({e_work[0], idx_frac}), .est(est)
    );

    always_comb begin
        sgn      = in_dp ? in_op[63] : in_op[31];
        rexp     = ((in_dp ? 14'(KOFF_D) : 14'(KOFF_S)) - 14'(e_work)) >>> 1;
        est_frac = est[7:0];
        dnan_v   = in_dp ? DNAN_D : DNAN_S;
        quiet_v  = in_dp ? {in_op[63:52], 1'b1, in_op[50:0]}
                         : {32'b0, in_op[31:23], 1'b1, in_op[21:0]};
        fin_v    = in_dp ? {1'b0, rexp[10:0], est_frac, 44'b0}
                         : {32'b0, 1'b0, rexp[7:0], est_frac, 15'b0};

        out_d       = '0;
        out_d.valid = in_valid;
        if (in_valid) begin
            out_d.idn = idn;
            unique case (cls)
                CLS_NAN: begin
                    out_d.inv = snan;
                    out_d.res = in_dnan ? dnan_v : quiet_v;
                end
                CLS_ZERO: begin
                    out_d.dz  = 1'b1;
                    out_d.res = in_dp ? (INF_D | {sgn, 63'b0})
                                      : (INF_S | {32'b0, sgn, 31'b0});
                end
                CLS_NEG: begin
                    out_d.inv = 1'b1;
                    out_d.res = dnan_v;
                end
                CLS_PINF: out_d.res = '0;
                default:  out_d.res = fin_v;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid   = out_q.valid;
    assign out_res     = out_q.res;
    assign out_invalid = out_q.inv;
    assign out_dzero   = out_q.dz;
    assign out_idenorm = out_q.idn;
endmodule

// File: rtl/rsq_est_chk.sv
module rsq_est_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_dp,
    input logic        out_valid,
    input logic [63:0] out_res,
    input logic        out_invalid,
    input logic        out_dzero,
    input logic        out_idenorm
);
    assert_valid_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_dz_gives_inf_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_dp) |=> (out_dzero -> out_res[62:0] == 63'h7FF0_0000_0000_0000));

    assert_dz_gives_inf_s_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_dp) |=> (out_dzero -> out_res[30:0] == 31'h7F80_0000));

    assert_flush_is_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_idenorm |-> out_dzero);

    assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_invalid && out_dzero));

    assert_upper_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_dp) |=> (out_res[63:32] == 32'h0));

    assert_invalid_is_nan_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_dp) |=> (out_invalid -> (out_res[62:52] == 11'h7FF && out_res[51])));
endmodule

bind rsq_est rsq_est_chk i_rsq_est_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dp(in_dp),
    .out_valid(out_valid), .out_res(out_res), .out_invalid(out_invalid),
    .out_dzero(out_dzero), .out_idenorm(out_idenorm)
);

// File: tb/test_rsq_est.sv
`timescale 1ns/1ps
module test_rsq_est;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_dp = 1'b0, in_ftz = 1'b0, in_dnan = 1'b0;
    logic [63:0] in_op = '0;
    logic        out_valid, out_invalid, out_dzero, out_idenorm;
    logic [63:0] out_res;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    rsq_est i_rsq_est (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dp(in_dp),
        .in_ftz(in_ftz), .in_dnan(in_dnan), .in_op(in_op),
        .out_valid(out_valid), .out_res(out_res), .out_invalid(out_invalid),
        .out_dzero(out_dzero), .out_idenorm(out_idenorm)
    );

    // returns {res, invalid, dzero, idenorm}
    function automatic logic [66:0] ref_model(input logic dp, input logic [63:0] op,
                                              input logic ftz, input logic dnan);
        logic        sgn, inv, dz, idn;
        int          expo, emax, e, q, s, rexp;
        logic [51:0] fr;
        logic [63:0] dn, res;
        real         r, den;
        sgn  = dp ? op[63] : op[31];
        expo = dp ? int'(op[62:52]) : int'(op[30:23]);
        emax = dp ? 2047 : 255;
        fr   = dp ? op[51:0] : {op[22:0], 29'b0};
        dn   = dp ? 64'h7FF8_0000_0000_0000 : 64'h7FC0_0000;
        inv = 0; dz = 0; idn = 0; res = '0;
        if (expo == 0 && fr != 0 && ftz) begin
            fr = '0; idn = 1;
        end
        if (expo == emax && fr != 0) begin
            inv = !fr[51];
            res = dnan ? dn : (dp ? {op[63:52], 1'b1, op[50:0]}
                                  : {32'b0, op[31:23], 1'b1, op[21:0]});
        end else if (expo == 0 && fr == 0) begin
            dz  = 1;
            res = dp ? {sgn, 63'h7FF0_0000_0000_0000} : {32'b0, sgn, 31'h7F80_0000};
        end else if (sgn) begin
            inv = 1; res = dn;
        end else if (expo == emax) begin
            res = '0;
        end else begin
            e = expo;
            if (e == 0) begin
                while (!fr[51]) begin fr = fr << 1; e = e - 1; end
                fr = fr << 1;
            end
            q   = 128 + int'(fr[51:45]);
            den = ((e & 1) != 0) ? 512.0 : 256.0;
            r   = 1.0 / $sqrt((q + 0.5) / den);
            s   = int'($floor(r * 256.0 + 0.5));
            rexp = ((dp ? 3068 : 380) - e) / 2;
            if (dp) res = {1'b0, 11'(rexp), 8'(s - 256), 44'b0};
            else    res = {32'b0, 1'b0, 8'(rexp), 8'(s - 256), 15'b0};
        end
        return {res, inv, dz, idn};
    endfunction

    task automatic check(input string tag, input logic [67:0] got, input logic [67:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(input string tag, input logic dp, input logic [63:0] op,
                         input logic ftz, input logic dnan);
        @(negedge clk);
        in_valid = 1; in_dp = dp; in_op = op; in_ftz = ftz; in_dnan = dnan;
        @(negedge clk);
        in_valid = 0;
        check(tag, {out_valid, out_res, out_invalid, out_dzero, out_idenorm},
              {1'b1, ref_model(dp, op, ftz, dnan)});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int unsigned sd;
        logic [63:0] rop;
        sd = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        check("R12 reset", {out_valid, out_res, out_invalid, out_dzero, out_idenorm}, '0);
        rst_n = 1;
        @(negedge clk);
        check("R12 idle", {67'b0, out_valid}, '0);

        apply("R1 qnan s",  0, 64'h7FC0_1234, 0, 0);
        apply("R1 snan s",  0, 64'h7F80_0001, 0, 0);
        apply("R1 snan d",  1, 64'h7FF0_0000_0000_0001, 0, 0);
        apply("R1 qnan d neg", 1, 64'hFFF8_0000_0000_00AB, 0, 0);
        apply("R2 dnan s",  0, 64'h7F80_0001, 0, 1);
        apply("R2 dnan d",  1, 64'hFFF8_0000_0000_0001, 0, 1);
        apply("R3 +0 s",    0, 64'h0, 0, 0);
        apply("R3 -0 s",    0, 64'h8000_0000, 0, 0);
        apply("R3 -0 d",    1, 64'h8000_0000_0000_0000, 0, 0);
        apply("R4 -1 s",    0, 64'hBF80_0000, 0, 0);
        apply("R4 -inf s",  0, 64'hFF80_0000, 0, 0);
        apply("R4 -2 d",    1, 64'hC000_0000_0000_0000, 0, 0);
        apply("R5 +inf s",  0, 64'h7F80_0000, 0, 0);
        apply("R5 +inf d",  1, 64'h7FF0_0000_0000_0000, 0, 0);
        apply("R6 ftz s",   0, 64'h0000_0001, 1, 0);
        apply("R6 ftz neg", 0, 64'h8040_0000, 1, 0);
        apply("R6 ftz d",   1, 64'h800F_FFFF_FFFF_FFFF, 1, 0);
        apply("R7 sub min s", 0, 64'h0000_0001, 0, 0);
        apply("R7 sub top s", 0, 64'h0040_0000, 0, 0);
        apply("R7 sub odd s", 0, 64'h0020_0000, 0, 0);
        apply("R7 sub min d", 1, 64'h1, 0, 0);
        apply("R7 sub top d", 1, 64'h0008_0000_0000_0000, 0, 0);
        apply("R9 min exp s", 0, 64'h0080_0000, 0, 0);
        apply("R9 max exp s", 0, 64'h7F7F_FFFF, 0, 0);
        apply("R9 max exp d", 1, 64'h7FEF_FFFF_FFFF_FFFF, 0, 0);
        apply("R11 one s",    0, 64'h3F80_0000, 0, 1);

        for (int p = 0; p < 2; p++) begin
            for (int t = 0; t < 128; t++) begin
                apply("R8 R10 R13 sweep s", 0,
                      {32'b0, 1'b0, 8'(126 + p), 7'(t), 16'hA5A5}, 0, 0);
                apply("R8 R10 sweep d", 1,
                      {1'b0, 11'(1022 + p), 7'(t), 45'h1234_5678_9AB}, 0, 0);
            end
        end

        for (int i = 0; i < 3000; i++) begin
            logic rdp;
            rdp = 1'($urandom);
            rop = {$urandom, $urandom};
            if ($urandom % 4 == 0) begin
                if (rdp) rop[62:52] = '0; else rop[30:23] = '0;
            end
            if ($urandom % 3 != 0) begin
                if (rdp) rop[63] = 0; else rop[31] = 0;
            end
            apply("R1 R6 R7 R9 R10 random", rdp, rop, 1'($urandom), 1'($urandom));
        end

        @(negedge clk);
        check("R12 drain", {67'b0, out_valid}, '0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule